// File: doc/BRIEF.md
# CAN Controller Operating-Mode and Bus Resynchronization Unit

This unit decides which operating mode a CAN protocol controller is in. A small CPU-facing register interface holds three control bits: soft reset, sleep request and loopback. From these bits the unit drives several outputs. It sends a one-cycle abort strobe and a hold level to the protocol engine. It gates CPU writes to the configuration registers, which may change only while soft reset is active. It runs the sleep request and acknowledge handshake. In loopback self-test it routes the transmit stream back to the receiver inside the controller.

After soft reset is released, the unit watches the effective receive bit each time the bit-time strobe fires. It reports the controller synchronized once it has seen a run of 11 consecutive recessive bits. If the node was bus-off when soft reset was released, it needs 128 such runs instead. The error counters live elsewhere and reach this unit only as a bus-off level. `rst_n` is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `canmode_ctrl`

## Requirements
- R1: After hard reset, soft reset reads 1. Sleep request, sleep acknowledge, loopback, synchronized and the abort strobe read 0, and `tx_pin` is recessive (1).
- R2: A write to register index 0 with bit 0 set, made while not in soft reset, enters soft reset on the next cycle. `abort_stb` is high for exactly the first cycle in which `soft_rst_o` reads 1.
- R3: While soft reset reads 1, a write to index 0 changes only soft reset (bit 0), and the sleep request (bit 1) stays 0. This holds even when the same write clears soft reset. Entering soft reset clears the sleep request on the same edge.
- R4: `cfg_prot_we` equals `cfg_wr` AND (index 1 to 12) AND soft reset, in the same cycle. Loopback (index 1, bit 0) changes only on such a gated write.
- R5: With soft reset clear and not bus-off, `synced_o` rises in the cycle after the `bit_stb` that carries the 11th consecutive recessive effective receive bit. A dominant bit restarts the run at zero.
- R6: If `bus_off` was high in the last cycle of soft reset, `synced_o` rises only after 128 completed runs of 11 recessive bits. The run counter restarts after each completed run. A dominant bit restarts only the current run.
- R7: `synced_o` drops one cycle after soft reset reads 1. Re-entering soft reset restarts both the run count and the completed-run count.
- R8: `sleep_ack_o` rises one cycle after sleep request, synchronized and not `frame_busy` all hold while soft reset is clear. It falls one cycle after the sleep request reads 0.
- R9: A dominant effective receive bit on `bit_stb` while `sleep_ack_o` is 1 clears both the acknowledge and the sleep request on the next cycle.
- R10: In loopback, `tx_pin` is 1, `rx_pin` is ignored, and `eng_rx_bit` follows `tx_bit`, except that it is 0 when `ack_slot` is high. Otherwise `eng_rx_bit` follows `rx_pin`, and `tx_pin` follows `tx_bit` unless soft reset forces it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| cfg_wr | input | 1 | CPU write strobe |
| cfg_addr | input | 4 | CPU register index |
| cfg_wdata | input | 8 | CPU write data |
| bus_off | input | 1 | Bus-off status from the error counters |
| frame_busy | input | 1 | Protocol engine has a frame in progress |
| tx_bit | input | 1 | Transmit bit from the protocol engine |
| ack_slot | input | 1 | Current bit is the acknowledge slot |
| rx_pin | input | 1 | Sampled receive pin |
| bit_stb | input | 1 | One-cycle strobe at each bit sample point |
| soft_rst_o | output | 1 | Soft reset state; also the engine hold level |
| sleep_req_o | output | 1 | Sleep request bit |
| sleep_ack_o | output | 1 | Sleep acknowledge flag |
| loopback_o | output | 1 | Loopback mode bit |
| synced_o | output | 1 | Synchronized to the bus |
| abort_stb | output | 1 | One-cycle abort pulse on soft reset entry |
| cfg_prot_we | output | 1 | Write enable for protected configuration registers |
| tx_pin | output | 1 | Transmit pin |
| eng_rx_bit | output | 1 | Effective receive bit to the protocol engine |

## Verification
The assertions assume that `bit_stb` is a one-cycle pulse. They also assume that `bus_off` holds steady around the release of soft reset and that `rst_n` is released synchronously. The bench pulses `bit_stb` for one cycle with an idle cycle after each pulse. It changes `bus_off` only while soft reset is active. It drives the bus value on `rx_pin` in normal mode and on `tx_bit` in loopback, and it keeps `ack_slot` low whenever a strobe fires.

// File: rtl/canmode_pkg.sv
package canmode_pkg;
  localparam int unsigned IDX_MAIN  = 0;
  localparam int unsigned IDX_MODE  = 1;
  localparam int unsigned POS_SRST  = 0;
  localparam int unsigned POS_SLEEP = 1;
  localparam int unsigned POS_LOOP  = 0;

  typedef enum logic [1:0] {
    RS_HOLD = 2'd0,
    RS_HUNT = 2'd1,
    RS_LOCK = 2'd2
  } rs_state_t;
endpackage

// File: rtl/canmode_regs.sv
module canmode_regs
  import canmode_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PROT_LO = 1,
  parameter int unsigned PROT_HI = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake,
  output logic              srst,
  output logic              req,
  output logic              loop_en,
  output logic              abort,
  output logic              prot_we
);
  localparam logic [ADDR_W-1:0] A_MAIN = ADDR_W'(IDX_MAIN);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(IDX_MODE);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(PROT_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(PROT_HI);

  logic srst_q, srst_d, prev_q;
  logic req_q, req_d;
  logic lb_q, lb_d;
  logic main_hit, mode_hit, ctl_en;
  logic unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:2];
  assign main_hit = wr && (addr == A_MAIN);
  assign mode_hit = wr && (addr == A_MODE) && srst_q;
  assign prot_we  = wr && (addr >= A_LO) && (addr <= A_HI) && srst_q;
  assign ctl_en   = main_hit || mode_hit || wake || srst_q;

  always_comb begin
    srst_d = srst_q;
    req_d  = req_q;
    lb_d   = lb_q;
    if (main_hit) begin
      srst_d = wdata[POS_SRST];
      if (!srst_q) req_d = wdata[POS_SLEEP];
    end
    if (mode_hit) lb_d = wdata[POS_LOOP];
    if (wake || srst_d) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b1;
      prev_q <= 1'b1;
      req_q  <= 1'b0;
      lb_q   <= 1'b0;
    end else begin
      prev_q <= srst_q;
      if (ctl_en) begin
        srst_q <= srst_d;
        req_q  <= req_d;
        lb_q   <= lb_d;
      end
    end
  end

  assign srst    = srst_q;
  assign req     = req_q;
  assign loop_en = lb_q;
  assign abort   = srst_q && !prev_q;
endmodule

// File: rtl/canmode_route.sv
module canmode_route (
  input  logic srst,
  input  logic loop_en,
  input  logic tx_bit,
  input  logic ack_slot,
  input  logic rx_pin,
  output logic tx_pin,
  output logic rx_eff
);
  always_comb begin
    tx_pin = (loop_en || srst) ? 1'b1 : tx_bit;
    if (loop_en) rx_eff = ack_slot ? 1'b0 : tx_bit;
    else         rx_eff = rx_pin;
  end
endmodule

// File: rtl/canmode_resync.sv
module canmode_resync
  import canmode_pkg::*;
#(
  parameter int unsigned RUN_BITS    = 11,
  parameter int unsigned BUSOFF_RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic bus_off,
  input  logic bit_stb,
  input  logic rx_bit,
  output logic synced
);
  localparam int unsigned RUN_W = $clog2(RUN_BITS);
  localparam int unsigned OCC_W = $clog2(BUSOFF_RUNS);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_BITS - 1);
  localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(BUSOFF_RUNS - 1);

  rs_state_t        st_q, st_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             need_q, need_d;
  logic             cnt_en;

  assign cnt_en = srst || ((st_q == RS_HUNT) && bit_stb);

  always_comb begin
    st_d   = st_q;
    run_d  = run_q;
    occ_d  = occ_q;
    need_d = need_q;
    if (srst) begin
      st_d   = RS_HOLD;
      run_d  = '0;
      occ_d  = '0;
      need_d = bus_off;
    end else if (st_q == RS_HOLD) begin
      st_d = RS_HUNT;
    end else if (st_q == RS_HUNT && bit_stb) begin
      if (!rx_bit) begin
        run_d = '0;
      end else if (run_q == RUN_LAST) begin
        run_d = '0;
        if (!need_q) begin
          st_d = RS_LOCK;
        end else if (occ_q == OCC_LAST) begin
          st_d  = RS_LOCK;
          occ_d = '0;
        end else begin
          occ_d = occ_q + 1'b1;
        end
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_HOLD;
      run_q  <= '0;
      occ_q  <= '0;
      need_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cnt_en) begin
        run_q  <= run_d;
        occ_q  <= occ_d;
        need_q <= need_d;
      end
    end
  end

  assign synced = (st_q == RS_LOCK);
endmodule

// File: rtl/canmode_sleep.sv
module canmode_sleep (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic req,
  input  logic synced,
  input  logic frame_busy,
  input  logic bit_stb,
  input  logic rx_bit,
  output logic ack,
  output logic wake
);
  logic ack_q, ack_d;

  assign wake = ack_q && bit_stb && !rx_bit;

  always_comb begin
    ack_d = ack_q;
    if (srst || !req || wake)        ack_d = 1'b0;
    else if (synced && !frame_busy)  ack_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign ack = ack_q;
endmodule

// File: rtl/canmode_ctrl.sv
module canmode_ctrl #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROT_LO     = 1,
  parameter int unsigned PROT_HI     = 12,
  parameter int unsigned RUN_BITS    = 11,
  parameter int unsigned BUSOFF_RUNS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              bus_off,
  input  logic              frame_busy,
  input  logic              tx_bit,
  input  logic              ack_slot,
  input  logic              rx_pin,
  input  logic              bit_stb,
  output logic              soft_rst_o,
  output logic              sleep_req_o,
  output logic              sleep_ack_o,
  output logic              loopback_o,
  output logic              synced_o,
  output logic              abort_stb,
  output logic              cfg_prot_we,
  output logic              tx_pin,
  output logic              eng_rx_bit
);
  logic srst, req, loop_en, wake, rx_eff, synced, ack;

  canmode_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PROT_LO(PROT_LO),
    .PROT_HI(PROT_HI)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .wake   (wake),
    .srst   (srst),
    .req    (req),
    .loop_en(loop_en),
    .abort  (abort_stb),
    .prot_we(cfg_prot_we)
  );

  canmode_route u_route (
    .srst    (srst),
    .loop_en (loop_en),
    .tx_bit  (tx_bit),
    .ack_slot(ack_slot),
    .rx_pin  (rx_pin),
    .tx_pin  (tx_pin),
    .rx_eff  (rx_eff)
  );

  canmode_resync #(
    .RUN_BITS   (RUN_BITS),
    .BUSOFF_RUNS(BUSOFF_RUNS)
  ) u_resync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst   (srst),
    .bus_off(bus_off),
    .bit_stb(bit_stb),
    .rx_bit (rx_eff),
    .synced (synced)
  );

  canmode_sleep u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (srst),
    .req       (req),
    .synced    (synced),
    .frame_busy(frame_busy),
    .bit_stb   (bit_stb),
    .rx_bit    (rx_eff),
    .ack       (ack),
    .wake      (wake)
  );

  assign soft_rst_o  = srst;
  assign sleep_req_o = req;
  assign sleep_ack_o = ack;
  assign loopback_o  = loop_en;
  assign synced_o    = synced;
  assign eng_rx_bit  = rx_eff;
endmodule

// File: rtl/canmode_ctrl_chk.sv
module canmode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_busy,
  input logic ack_slot,
  input logic bit_stb,
  input logic soft_rst_o,
  input logic sleep_req_o,
  input logic sleep_ack_o,
  input logic loopback_o,
  input logic synced_o,
  input logic abort_stb,
  input logic cfg_prot_we,
  input logic tx_pin,
  input logic eng_rx_bit
);
  a_r2_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> !abort_stb);
  a_r2_abort_in_srst: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |-> soft_rst_o);
  a_r3_no_req_in_srst: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> !sleep_req_o);
  a_r4_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_prot_we |-> soft_rst_o);
  a_r4_loop_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_o |=> $stable(loopback_o));
  a_r5_sync_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced_o) |-> $past(bit_stb));
  a_r7_srst_drops_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst_o) |=> !synced_o);
  a_r8_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack_o |-> $past(sleep_req_o));
  a_r8_ack_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack_o) |-> $past(synced_o && !frame_busy));
  a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ack_o && bit_stb && !eng_rx_bit) |=> (!sleep_ack_o && !sleep_req_o));
  a_r10_loop_tx: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_o |-> tx_pin);
  a_r10_loop_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback_o && ack_slot) |-> !eng_rx_bit);
endmodule

bind canmode_ctrl canmode_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_busy (frame_busy),
  .ack_slot   (ack_slot),
  .bit_stb    (bit_stb),
  .soft_rst_o (soft_rst_o),
  .sleep_req_o(sleep_req_o),
  .sleep_ack_o(sleep_ack_o),
  .loopback_o (loopback_o),
  .synced_o   (synced_o),
  .abort_stb  (abort_stb),
  .cfg_prot_we(cfg_prot_we),
  .tx_pin     (tx_pin),
  .eng_rx_bit (eng_rx_bit)
);

// File: tb/canmode_ctrl_test.sv
module canmode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       bus_off = 1'b0, frame_busy = 1'b0, tx_bit = 1'b1;
  logic       ack_slot = 1'b0, rx_pin = 1'b1, bit_stb = 1'b0;
  logic soft_rst_o, sleep_req_o, sleep_ack_o, loopback_o, synced_o;
  logic abort_stb, cfg_prot_we, tx_pin, eng_rx_bit;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  string phase = "R1 reset";

  // behavioural reference state
  bit m_srst = 1, m_prev = 1, m_req = 0, m_lb = 0, m_ack = 0, m_sync = 0, m_need = 0, m_hunt = 0;
  int m_run = 0, m_occ = 0;

  canmode_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_rx();
    if (m_lb) return ack_slot ? 1'b0 : tx_bit;
    return rx_pin;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_srst = 1; m_prev = 1; m_req = 0; m_lb = 0; m_ack = 0;
      m_sync = 0; m_need = 0; m_hunt = 0; m_run = 0; m_occ = 0;
    end else begin
      bit wk, s, r, l, a;
      wk = m_ack && bit_stb && !exp_rx();
      s = m_srst; r = m_req; l = m_lb;
      if (cfg_wr && cfg_addr == 4'd0) begin
        s = cfg_wdata[0];
        if (!m_srst) r = cfg_wdata[1];
      end
      if (cfg_wr && cfg_addr == 4'd1 && m_srst) l = cfg_wdata[0];
      if (wk || s) r = 0;
      a = m_ack;
      if (m_srst || !m_req || wk) a = 0;
      else if (m_sync && !frame_busy) a = 1;
      if (m_srst) begin
        m_run = 0; m_occ = 0; m_sync = 0; m_need = bus_off; m_hunt = 0;
      end else if (!m_hunt) begin
        m_hunt = 1;
      end else if (!m_sync && bit_stb) begin
        if (!exp_rx()) m_run = 0;
        else begin
          m_run++;
          if (m_run == 11) begin
            m_run = 0;
            if (!m_need) m_sync = 1;
            else begin
              m_occ++;
              if (m_occ == 128) m_sync = 1;
            end
          end
        end
      end
      m_prev = m_srst;
      m_srst = s; m_req = r; m_lb = l; m_ack = a;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R2 soft_rst", soft_rst_o, m_srst);
    chk("R2 abort", abort_stb, m_srst && !m_prev);
    chk("R3 sleep_req", sleep_req_o, m_req);
    chk("R4 prot_we", cfg_prot_we, cfg_wr && cfg_addr >= 4'd1 && cfg_addr <= 4'd12 && m_srst);
    chk("R4 loopback", loopback_o, m_lb);
    chk("R5 synced", synced_o, m_sync);
    chk("R8 sleep_ack", sleep_ack_o, m_ack);
    chk("R10 tx_pin", tx_pin, (m_lb || m_srst) ? 1'b1 : tx_bit);
    chk("R10 eng_rx", eng_rx_bit, exp_rx());
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_wr = 0;
  endtask

  task automatic bits(int n, logic v, bit on_tx);
    repeat (n) begin
      if (on_tx) tx_bit = v; else rx_pin = v;
      bit_stb = 1; tick(1);
      bit_stb = 0; tick(1);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      checks++; fails++;
      $display("FAIL watchdog [%s] actual=%0d cycles expected<=%0d", phase, cycles, LIMIT);
      finish_up();
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    phase = "R4 gated config writes";
    wr(4'd3, 8'hAA); wr(4'd12, 8'h55); wr(4'd13, 8'h11); wr(4'd1, 8'h00);
    phase = "R3 release ignores sleep bit";
    wr(4'd0, 8'h02); tick(2);
    phase = "R5 resync after release";
    bits(5, 1, 0); bits(1, 0, 0); bits(10, 1, 0); tick(2); bits(1, 1, 0); tick(2);
    phase = "R4 locked outside soft reset";
    wr(4'd1, 8'h01); wr(4'd5, 8'hFF); tick(1);
    phase = "R8 sleep handshake";
    frame_busy = 1; wr(4'd0, 8'h02); tick(4);
    frame_busy = 0; tick(3);
    wr(4'd0, 8'h00); tick(3);
    phase = "R9 wake on activity";
    wr(4'd0, 8'h02); tick(3);
    bits(2, 1, 0); bits(1, 0, 0); tick(3); rx_pin = 1;
    phase = "R10 normal routing";
    tx_bit = 0; tick(2); tx_bit = 1; tick(2); rx_pin = 0; tick(1); rx_pin = 1; tick(1);
    phase = "R2 enter soft reset";
    wr(4'd0, 8'h01); tick(3); wr(4'd0, 8'h03); tick(2);
    phase = "R6 bus-off resync in loopback";
    bus_off = 1; wr(4'd1, 8'h01); rx_pin = 0; tick(2);
    wr(4'd0, 8'h00); tick(1);
    ack_slot = 1; tick(2); ack_slot = 0; tick(1);
    bits(500, 1, 1); bits(1, 0, 1); bits(1408, 1, 1); tick(3);
    phase = "R7 restart counts on soft reset";
    wr(4'd0, 8'h01); tick(2); bus_off = 0; wr(4'd1, 8'h00); rx_pin = 1; tx_bit = 1;
    wr(4'd0, 8'h00); tick(1);
    bits(8, 1, 0); wr(4'd0, 8'h01); wr(4'd0, 8'h00); tick(1);
    bits(10, 1, 0); tick(2); bits(1, 1, 0); tick(3);
    finish_up();
  end
endmodule